// File: doc/BRIEF.md
# Isolated Channel Pulse Decoder with Activity Watchdog

This block sits on the receive side of one isolated logic channel. Edges on the far side arrive as single-cycle strobes: a set strobe means the remote input went high and a clear strobe means it went low. The same strobes also arrive periodically while the remote input is static, which refreshes the level. A bistable latch turns the strobes back into a steady logic level.

If strobes stop arriving for a programmable number of clock cycles, the block assumes that the transmit side has lost power or failed. It then forces the output to a safe low default and raises a flag. The flag stays up until the next strobe arrives.

A local supply-good input gates everything. While it is low, the output driver is disabled (high impedance) and the latch is held low. When it rises, the driver is enabled and the output stays low until the first strobe arrives. If both strobes arrive in the same cycle, the clear strobe takes priority and an error flag is raised for one cycle.

Top module: `pd_rx_decoder`

## Requirements
- R1: While `rst` is high, and in the cycle after, `data_out`, `out_en`, `clash_err` and `dflt_active` are all 0.
- R2: With `supply_ok`=1, a cycle with only `set_stb`=1 makes `data_out`=1 after that clock edge. A cycle with only `clr_stb`=1 makes `data_out`=0 after that edge.
- R3: With `supply_ok`=1 and no strobe, `data_out` keeps its value for up to TIMEOUT_CYC-1 consecutive idle cycles.
- R4: If `set_stb` and `clr_stb` are both 1 in one cycle, `data_out` becomes 0 after that edge. `clash_err` is then 1 for exactly that one following cycle.
- R5: After TIMEOUT_CYC consecutive idle cycles with `supply_ok`=1, `data_out` is 0 and `dflt_active` is 1. After only TIMEOUT_CYC-1 idle cycles, `dflt_active` is still 0.
- R6: Any strobe restarts the idle count, so refresh strobes spaced at most TIMEOUT_CYC-1 idle cycles apart keep `data_out` at its level indefinitely.
- R7: `dflt_active` clears on the edge of the next strobe, and `data_out` takes the value that strobe carries.
- R8: A cycle with `supply_ok`=0 gives `out_en`=0, `data_out`=0, `dflt_active`=0 and `clash_err`=0 after that edge. Strobes in such cycles have no effect.
- R9: On the first edge with `supply_ok`=1 after lockout, `out_en` becomes 1. `data_out` stays 0 until a set strobe arrives, and the idle count starts from zero.
- R10: `clash_err` is 0 after any cycle in which at most one strobe was present.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_stb | input | 1 | Set strobe (remote level high) |
| clr_stb | input | 1 | Clear strobe (remote level low) |
| supply_ok | input | 1 | Local supply out of lockout |
| data_out | output | 1 | Recovered logic level |
| out_en | output | 1 | Output driver enable; 0 means high impedance |
| clash_err | output | 1 | Both strobes seen in the previous cycle |
| dflt_active | output | 1 | Watchdog default is forcing the output low |

## Verification
The bench sweeps the idle gap after a set strobe from zero to past the timeout. A counter that is off by one would drop the level one cycle early or late, and the bench checks every cycle of the gap to catch either. It drives refresh strobes exactly at the last safe spacing. A design that fails to restart the count on every strobe would time out and pull the output low there. It walks every pair of consecutive strobe and supply combinations. This catches set winning a clash, a clash flag that sticks, strobes leaking through lockout, and an output that comes out of lockout high instead of low.

// File: rtl/pd_pkg.sv
package pd_pkg;

    typedef enum logic [1:0] {
        CMD_IDLE  = 2'd0,
        CMD_SET   = 2'd1,
        CMD_CLR   = 2'd2,
        CMD_CLASH = 2'd3
    } strobe_cmd_e;

    typedef struct packed {
        logic level;
        logic enable;
        logic clash;
        logic defaulted;
    } out_state_t;

    localparam out_state_t OUT_SAFE = '{level: 1'b0, enable: 1'b0, clash: 1'b0, defaulted: 1'b0};

    function automatic strobe_cmd_e decode_strobes(input logic s, input logic c);
        if (s && c)  return CMD_CLASH;
        else if (s)  return CMD_SET;
        else if (c)  return CMD_CLR;
        else         return CMD_IDLE;
    endfunction

    function automatic logic cmd_is_pulse(input strobe_cmd_e cmd);
        return cmd != CMD_IDLE;
    endfunction

endpackage

// File: rtl/pd_strobe_decode.sv
module pd_strobe_decode
    import pd_pkg::*;
(
    input  logic        set_stb,
    input  logic        clr_stb,
    output strobe_cmd_e cmd,
    output logic        pulse
);
    always_comb begin
        cmd   = decode_strobes(set_stb, clr_stb);
        pulse = cmd_is_pulse(cmd);
    end
endmodule

// File: rtl/pd_activity_wdog.sv
module pd_activity_wdog #(
    parameter int unsigned TIMEOUT_CYC = 500
) (
    input  logic clk,
    input  logic rst,
    input  logic supply_ok,
    input  logic pulse,
    output logic expire
);
    localparam int unsigned CW    = $clog2(TIMEOUT_CYC) + 1;
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

    logic [CW-1:0] idle_cnt;

    always_comb begin
        expire = supply_ok && !pulse && (idle_cnt == LAST);
    end

    always_ff @(posedge clk) begin
        if (rst || !supply_ok || pulse) begin
            idle_cnt <= '0;
        end else if (idle_cnt != LAST) begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end

    // R6: a strobe always restarts the idle count
    assert_restart_R6: assert property (@(posedge clk) disable iff (rst)
        (supply_ok && pulse) |=> (idle_cnt == '0));

    // R8 / R9: lockout clears the count so it restarts on exit
    assert_lockout_clear_R9: assert property (@(posedge clk) disable iff (rst)
        !supply_ok |=> (idle_cnt == '0));

endmodule

// File: rtl/pd_out_stage.sv
module pd_out_stage
    import pd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        supply_ok,
    input  strobe_cmd_e cmd,
    input  logic        expire,
    output out_state_t  st
);
    out_state_t nxt;

    always_comb begin
        nxt = st;
        if (!supply_ok) begin
            nxt = OUT_SAFE;
        end else begin
            nxt.enable = 1'b1;
            nxt.clash  = (cmd == CMD_CLASH);
            unique case (cmd)
                CMD_SET: begin
                    nxt.level     = 1'b1;
                    nxt.defaulted = 1'b0;
                end
                CMD_CLR, CMD_CLASH: begin
                    nxt.level     = 1'b0;
                    nxt.defaulted = 1'b0;
                end
                default: begin
                    if (expire) begin
                        nxt.level     = 1'b0;
                        nxt.defaulted = 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= OUT_SAFE;
        else     st <= nxt;
    end

    assert_set_high_R2: assert property (@(posedge clk) disable iff (rst)
        (supply_ok && cmd == CMD_SET) |=> st.level);

    assert_clash_low_R4: assert property (@(posedge clk) disable iff (rst)
        (supply_ok && cmd == CMD_CLASH) |=> (!st.level && st.clash));

    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (supply_ok && cmd == CMD_IDLE && !expire) |=> $stable(st.level));

    assert_lockout_R8: assert property (@(posedge clk) disable iff (rst)
        !supply_ok |=> (!st.enable && !st.level && !st.defaulted));

endmodule

// File: rtl/pd_rx_decoder.sv
module pd_rx_decoder #(
    parameter int unsigned TIMEOUT_CYC = 500
) (
    input  logic clk,
    input  logic rst,
    input  logic set_stb,
    input  logic clr_stb,
    input  logic supply_ok,
    output logic data_out,
    output logic out_en,
    output logic clash_err,
    output logic dflt_active
);
    import pd_pkg::*;

    strobe_cmd_e cmd;
    logic        pulse;
    logic        expire;
    out_state_t  st;

    pd_strobe_decode u_dec (
        .set_stb (set_stb),
        .clr_stb (clr_stb),
        .cmd     (cmd),
        .pulse   (pulse)
    );

    pd_activity_wdog #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_wdog (
        .clk       (clk),
        .rst       (rst),
        .supply_ok (supply_ok),
        .pulse     (pulse),
        .expire    (expire)
    );

    pd_out_stage u_out (
        .clk       (clk),
        .rst       (rst),
        .supply_ok (supply_ok),
        .cmd       (cmd),
        .expire    (expire),
        .st        (st)
    );

    always_comb begin
        data_out    = st.level;
        out_en      = st.enable;
        clash_err   = st.clash;
        dflt_active = st.defaulted;
    end

    assert_default_low_R5: assert property (@(posedge clk) disable iff (rst)
        dflt_active |-> !data_out);

    assert_clash_cause_R10: assert property (@(posedge clk) disable iff (rst)
        !(supply_ok && set_stb && clr_stb) |=> !clash_err);

    assert_default_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (supply_ok && (set_stb || clr_stb)) |=> !dflt_active);

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (!data_out && !out_en && !clash_err && !dflt_active));

endmodule

// File: tb/pd_rx_decoder_tb_top.sv
`timescale 1ns/1ps
module pd_rx_decoder_tb_top;
    localparam int T = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic set_stb = 1'b0, clr_stb = 1'b0, supply_ok = 1'b0;
    logic data_out, out_en, clash_err, dflt_active;

    int n_checks = 0;
    int n_errors = 0;

    // reference state
    logic m_d = 0, m_en = 0, m_err = 0, m_df = 0, m_prev_ok = 0;
    int   m_cnt = 0;

    always #5 clk = ~clk;

    pd_rx_decoder #(.TIMEOUT_CYC(T)) dut_i (
        .clk(clk), .rst(rst), .set_stb(set_stb), .clr_stb(clr_stb),
        .supply_ok(supply_ok), .data_out(data_out), .out_en(out_en),
        .clash_err(clash_err), .dflt_active(dflt_active)
    );

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // One clock: drive inputs, advance, check all outputs against the requirements.
    task automatic step(input logic s, input logic c, input logic ok, input string force_tag);
        string tag;
        set_stb = s; clr_stb = c; supply_ok = ok;
        @(posedge clk); #2;
        if (!ok) begin
            m_d = 0; m_en = 0; m_err = 0; m_df = 0; m_cnt = 0; tag = "R8";
        end else begin
            m_en = 1; m_err = s && c;
            if (s || c) begin
                tag = (s && c) ? "R4" : (m_df ? "R7" : "R2");
                m_d = s && !c; m_df = 0; m_cnt = 0;
            end else if (m_cnt == T - 1) begin
                m_d = 0; m_df = 1; tag = "R5";
            end else begin
                m_cnt++; tag = m_df ? "R5" : "R3";
            end
            if (!m_prev_ok) tag = "R9";
        end
        m_prev_ok = ok;
        if (force_tag != "") tag = force_tag;
        chk(tag, "data_out", data_out, m_d);
        chk(tag, "out_en", out_en, m_en);
        chk(m_err ? "R4" : "R10", "clash_err", clash_err, m_err);
        chk(tag, "dflt_active", dflt_active, m_df);
    endtask

    initial begin : watchdog
        #1500000;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        // R1: reset state
        @(posedge clk); #2;
        @(posedge clk); #2;
        chk("R1", "data_out", data_out, 1'b0);
        chk("R1", "out_en", out_en, 1'b0);
        chk("R1", "clash_err", clash_err, 1'b0);
        chk("R1", "dflt_active", dflt_active, 1'b0);
        rst = 0;

        // R8: strobes ignored in lockout
        step(1, 0, 0, "R8");
        step(1, 1, 0, "R8");
        // R9: exit lockout, output stays low
        step(0, 0, 1, "R9");
        step(0, 0, 1, "R9");

        // R3/R5: sweep idle gap lengths after a set strobe
        for (int gap = 0; gap <= T + 2; gap++) begin
            step(1, 0, 1, "");
            for (int k = 0; k < gap; k++) step(0, 0, 1, "");
        end

        // R6: refresh at the last safe spacing keeps level high
        for (int r = 0; r < 4; r++) begin
            step(1, 0, 1, "R6");
            for (int k = 0; k < T - 1; k++) step(0, 0, 1, "R6");
        end
        // let it expire, then R7 recovery with set and clear
        for (int k = 0; k < 2; k++) step(0, 0, 1, "");
        step(1, 0, 1, "R7");
        for (int k = 0; k < T; k++) step(0, 0, 1, "");
        step(0, 1, 1, "R7");

        // R4 from high
        step(1, 0, 1, "");
        step(1, 1, 1, "R4");
        step(0, 0, 1, "R10");

        // all pairs of consecutive input combinations
        for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 8; b++) begin
                step(a[0], a[1], a[2], "");
                step(b[0], b[1], b[2], "");
                step(0, 0, 1, "");
            end
        end

        // R8: lockout while high
        step(1, 0, 1, "");
        step(0, 0, 0, "R8");
        step(1, 0, 0, "R8");
        step(0, 0, 1, "R9");

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule